// File: doc/BRIEF.md
# Cartridge Bus Responder with Fast Jump

This block answers reads from an 8-bit host processor on a cartridge port that carries only a 13-bit address, with no read strobe and no bus clock. The top address line selects the cartridge and the low twelve lines give the byte offset. The block samples the address on its own fast clock. It treats a read as new only when the address has moved to a different value and then stayed there long enough. It fetches the byte from an external ROM read port and drives it on the data bus.

The block also has a fast-jump mode. When the host fetches an absolute-jump opcode (`$4C`) and both of its operand bytes in ROM are zero, the next two operand reads are answered from a jump stream in display RAM. The first byte taken from that stream is the low byte of the target and the second is the high byte. A pointer register selects the stream position. The pointer advances after each completed jump and can be loaded through a separate port.

A processor can read the same address twice in a row, for example a dummy read after a single-byte instruction. Because accesses are found only from address changes, such a read cannot advance the pointer or arm the jump mode.

Top module: `cart_fastjump_responder`

## Requirements
- R1: The data bus is driven (`bus_drive_o`=1) only after an access whose address bit 12 is 1. An access with bit 12 equal to 0 turns the drive off and cancels an armed fast jump.
- R2: A normal access returns the ROM byte at offset bits 11:0. The byte appears after the (STABLE_CNT+4)-th rising edge that samples the new address, and it holds until the next accepted access.
- R3: An address that is held, or read again without changing, creates no further access. The pointer and the fast-jump state do not change.
- R4: An address value must be seen on STABLE_CNT+1 consecutive samples before it is accepted. A shorter excursion that returns to the previous address has no effect.
- R5: After an access at offset N returns `$4C` while ROM holds `$00` at N+1 and at N+2, the next access at N+1 returns RAM[ptr] and the following access at N+2 returns RAM[ptr+1].
- R6: The second override read advances the pointer by 2, modulo 2^PTR_W.
- R7: If either operand byte at N+1 or N+2 is not zero, the jump is served from ROM and the pointer does not change.
- R8: While fast jump is armed, any access other than the expected next operand offset cancels the mode. That access and all later ones are served from ROM, and the pointer does not change.
- R9: A pulse on `jptr_load_i` writes `jptr_value_i` into the pointer at that clock edge. A load overrides an advance in the same cycle.
- R10: After reset the drive is off, the pointer is 0 and no fast jump is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 13 | Asynchronous host address, bit 12 selects the cartridge |
| bus_data_o | output | 8 | Byte presented to the host |
| bus_drive_o | output | 1 | Data bus drive enable |
| rom_addr_o | output | 12 | ROM read address |
| rom_data_i | input | 8 | ROM read data, combinational from rom_addr_o |
| ram_addr_o | output | 12 | Display RAM read address for the jump stream |
| ram_data_i | input | 8 | Display RAM read data, combinational from ram_addr_o |
| jptr_load_i | input | 1 | Load strobe for the jump stream pointer |
| jptr_value_i | input | 12 | Value written on a load |
| jptr_o | output | 12 | Current jump stream pointer |

## Verification
Plain reads of offsets with different ROM contents, including the last offset, show that the offset is decoded correctly and that the drive depends on bit 12. A short glitch, a held address and a NOP whose trailing dummy read merges with the following jump fetch separate real address transitions from repeated reads. Jumps whose operands are zero, jumps with a nonzero operand, jumps interrupted after either operand and a jump at the pointer's wrap point separate the override path from ROM service. In each case the pointer shows whether it advanced. A behavioural model predicts the drive, the data and the pointer on every cycle.

// File: rtl/cfj_pkg.sv
`timescale 1ns/1ps
package cfj_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] OP_JMP_ABS = 8'h4C;

    typedef enum logic [2:0] {
        FJ_IDLE     = 3'd0,
        FJ_PROBE_LO = 3'd1,
        FJ_PROBE_HI = 3'd2,
        FJ_WAIT_LO  = 3'd3,
        FJ_WAIT_HI  = 3'd4
    } fj_state_e;

    function automatic logic is_zero_operand(input logic [BYTE_W-1:0] b);
        return b == '0;
    endfunction

endpackage

// File: rtl/cfj_addr_tracker.sv
`timescale 1ns/1ps
module cfj_addr_tracker #(
    parameter int ADDR_W     = 13,
    parameter int STABLE_CNT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              new_acc_o
);
    localparam int CNT_W = $clog2(STABLE_CNT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CNT - 1);

    logic [ADDR_W-1:0] sync1_q, sync2_q, cand_q, acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              new_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            cand_q  <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
            new_q   <= 1'b0;
        end else begin
            sync1_q <= bus_addr_i;
            sync2_q <= sync1_q;
            new_q   <= 1'b0;
            if (sync2_q != cand_q) begin
                cand_q <= sync2_q;
                cnt_q  <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (cand_q != acc_q) begin
                acc_q <= cand_q;
                new_q <= 1'b1;
            end
        end
    end

    assign acc_addr_o = acc_q;
    assign new_acc_o  = new_q;
endmodule

// File: rtl/cfj_fetch_engine.sv
`timescale 1ns/1ps
module cfj_fetch_engine
    import cfj_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter int PTR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              new_acc_i,
    input  logic              sel_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [OFS_W-1:0]  rom_addr_o,
    input  logic [BYTE_W-1:0] rom_data_i,
    output logic [PTR_W-1:0]  ram_addr_o,
    input  logic [BYTE_W-1:0] ram_data_i,
    input  logic              ptr_load_i,
    input  logic [PTR_W-1:0]  ptr_value_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              drive_o
);
    fj_state_e         state_q;
    logic [OFS_W-1:0]  probe_q, expect_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] data_q;
    logic              drive_q;
    logic              hit_lo, hit_hi;
    logic [BYTE_W-1:0] serve_byte;

    always_comb begin
        hit_lo     = (state_q == FJ_WAIT_LO) && sel_i && (ofs_i == expect_q);
        hit_hi     = (state_q == FJ_WAIT_HI) && sel_i && (ofs_i == expect_q);
        rom_addr_o = new_acc_i ? ofs_i : probe_q;
        ram_addr_o = (state_q == FJ_WAIT_HI) ? ptr_q + PTR_W'(1) : ptr_q;
        serve_byte = (hit_lo || hit_hi) ? ram_data_i : rom_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FJ_IDLE;
            probe_q  <= '0;
            expect_q <= '0;
            ptr_q    <= '0;
            data_q   <= '0;
            drive_q  <= 1'b0;
        end else begin
            if (new_acc_i) begin
                drive_q <= sel_i;
                data_q  <= serve_byte;
                if (hit_lo) begin
                    state_q  <= FJ_WAIT_HI;
                    expect_q <= ofs_i + OFS_W'(1);
                end else if (hit_hi) begin
                    state_q <= FJ_IDLE;
                    ptr_q   <= ptr_q + PTR_W'(2);
                end else if (sel_i && rom_data_i == OP_JMP_ABS) begin
                    state_q  <= FJ_PROBE_LO;
                    probe_q  <= ofs_i + OFS_W'(1);
                    expect_q <= ofs_i + OFS_W'(1);
                end else begin
                    state_q <= FJ_IDLE;
                end
            end else begin
                case (state_q)
                    FJ_PROBE_LO: begin
                        if (is_zero_operand(rom_data_i)) begin
                            state_q <= FJ_PROBE_HI;
                            probe_q <= probe_q + OFS_W'(1);
                        end else begin
                            state_q <= FJ_IDLE;
                        end
                    end
                    FJ_PROBE_HI: begin
                        state_q <= is_zero_operand(rom_data_i) ? FJ_WAIT_LO : FJ_IDLE;
                    end
                    default: ;
                endcase
            end
            if (ptr_load_i) begin
                ptr_q <= ptr_value_i;
            end
        end
    end

    assign ptr_o   = ptr_q;
    assign data_o  = data_q;
    assign drive_o = drive_q;
endmodule

// File: rtl/cart_fastjump_responder.sv
`timescale 1ns/1ps
module cart_fastjump_responder
    import cfj_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PTR_W      = 12,
    parameter int STABLE_CNT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    output logic [BYTE_W-1:0]   bus_data_o,
    output logic                bus_drive_o,
    output logic [ADDR_W-2:0]   rom_addr_o,
    input  logic [BYTE_W-1:0]   rom_data_i,
    output logic [PTR_W-1:0]    ram_addr_o,
    input  logic [BYTE_W-1:0]   ram_data_i,
    input  logic                jptr_load_i,
    input  logic [PTR_W-1:0]    jptr_value_i,
    output logic [PTR_W-1:0]    jptr_o
);
    localparam int OFS_W = ADDR_W - 1;

    logic [ADDR_W-1:0] acc_addr;
    logic              new_acc;

    cfj_addr_tracker #(
        .ADDR_W    (ADDR_W),
        .STABLE_CNT(STABLE_CNT)
    ) tracker_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr_i(bus_addr_i),
        .acc_addr_o(acc_addr),
        .new_acc_o (new_acc)
    );

    cfj_fetch_engine #(
        .OFS_W(OFS_W),
        .PTR_W(PTR_W)
    ) engine_i (
        .clk        (clk),
        .rst        (rst),
        .new_acc_i  (new_acc),
        .sel_i      (acc_addr[ADDR_W-1]),
        .ofs_i      (acc_addr[OFS_W-1:0]),
        .rom_addr_o (rom_addr_o),
        .rom_data_i (rom_data_i),
        .ram_addr_o (ram_addr_o),
        .ram_data_i (ram_data_i),
        .ptr_load_i (jptr_load_i),
        .ptr_value_i(jptr_value_i),
        .ptr_o      (jptr_o),
        .data_o     (bus_data_o),
        .drive_o    (bus_drive_o)
    );
endmodule

// File: rtl/cfj_checker.sv
`timescale 1ns/1ps
module cfj_checker #(
    parameter int PTR_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             new_acc,
    input logic             acc_sel,
    input logic             bus_drive_o,
    input logic [7:0]       bus_data_o,
    input logic             jptr_load_i,
    input logic [PTR_W-1:0] jptr_o
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q && !rst) begin
            a_r10_quiet_after_reset: assert (!bus_drive_o && jptr_o == '0);
        end
    end

    a_r1_drive_follows_select: assert property (@(posedge clk) disable iff (rst)
        new_acc |=> (bus_drive_o == $past(acc_sel)));

    a_r2_data_holds_between_events: assert property (@(posedge clk) disable iff (rst)
        !new_acc |=> $stable(bus_data_o) && $stable(bus_drive_o));

    a_r3_ptr_quiet_without_event: assert property (@(posedge clk) disable iff (rst)
        (!new_acc && !jptr_load_i) |=> $stable(jptr_o));

    a_r4_events_isolated: assert property (@(posedge clk) disable iff (rst)
        new_acc |=> !new_acc);

    a_r6_ptr_steps_by_two: assert property (@(posedge clk) disable iff (rst)
        (new_acc && !jptr_load_i) |=>
            (jptr_o == $past(jptr_o) || jptr_o == $past(jptr_o) + PTR_W'(2)));
endmodule

bind cart_fastjump_responder cfj_checker #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .new_acc    (new_acc),
    .acc_sel    (acc_addr[ADDR_W-1]),
    .bus_drive_o(bus_drive_o),
    .bus_data_o (bus_data_o),
    .jptr_load_i(jptr_load_i),
    .jptr_o     (jptr_o)
);

// File: tb/cart_fastjump_responder_tb_top.sv
`timescale 1ns/1ps
module cart_fastjump_responder_tb_top;
    localparam int STB = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_data;
    logic        bus_drive;
    logic [11:0] rom_addr, ram_addr, jptr, jval = '0;
    logic [7:0]  rom_data, ram_data;
    logic        jload = 1'b0;

    logic [7:0] rom [4096];
    logic [7:0] ram [4096];

    int checks = 0, errors = 0;
    bit done = 0;
    string phase = "R10";

    always #4 clk = ~clk;

    assign rom_data = rom[rom_addr];
    assign ram_data = ram[ram_addr];

    cart_fastjump_responder #(.STABLE_CNT(STB)) dut_i (
        .clk(clk), .rst(rst), .bus_addr_i(bus_addr), .bus_data_o(bus_data),
        .bus_drive_o(bus_drive), .rom_addr_o(rom_addr), .rom_data_i(rom_data),
        .ram_addr_o(ram_addr), .ram_data_i(ram_data), .jptr_load_i(jload),
        .jptr_value_i(jval), .jptr_o(jptr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int due; int addr; } pend_t;
    int    hist[$];
    pend_t pq[$];
    int    edge_n, m_acc, m_ptr, m_exp, m_mode, m_data;
    bit    m_drive;

    function automatic void model_serve(input int a);
        int sel, ofs;
        sel = (a >> 12) & 1;
        ofs = a & 12'hFFF;
        if (m_mode == 1 && sel == 1 && ofs == m_exp) begin
            m_data = ram[m_ptr];
            m_mode = 2;
            m_exp  = (ofs + 1) & 12'hFFF;
        end else if (m_mode == 2 && sel == 1 && ofs == m_exp) begin
            m_data = ram[(m_ptr + 1) & 12'hFFF];
            m_ptr  = (m_ptr + 2) & 12'hFFF;
            m_mode = 0;
        end else begin
            m_data = rom[ofs];
            if (sel == 1 && rom[ofs] == 8'h4C && rom[(ofs + 1) & 12'hFFF] == 8'h00
                && rom[(ofs + 2) & 12'hFFF] == 8'h00) begin
                m_mode = 1;
                m_exp  = (ofs + 1) & 12'hFFF;
            end else begin
                m_mode = 0;
            end
        end
        m_drive = (sel == 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            for (int i = 0; i <= STB; i++) hist.push_back(0);
            pq.delete();
            edge_n = 0; m_acc = 0; m_ptr = 0; m_exp = 0; m_mode = 0;
            m_data = 0; m_drive = 0;
        end else begin
            bit same;
            edge_n++;
            while (pq.size() > 0 && pq[0].due == edge_n) begin
                model_serve(pq[0].addr);
                void'(pq.pop_front());
            end
            if (jload) m_ptr = int'(jval);
            hist.push_back(int'(bus_addr));
            if (hist.size() > STB + 1) void'(hist.pop_front());
            same = 1;
            for (int i = 1; i < hist.size(); i++) if (hist[i] != hist[0]) same = 0;
            if (same && hist[0] != m_acc) begin
                m_acc = hist[0];
                pq.push_back('{edge_n + 3, hist[0]});
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(phase, int'(bus_drive), int'(m_drive));
            if (m_drive) chk(phase, int'(bus_data), m_data);
            chk(phase, int'(jptr), m_ptr);
        end
    end

    // ---------------- stimulus ----------------
    task automatic visit(input logic [12:0] a, input string tag,
                         input bit exp_drv, input int exp_dat);
        @(negedge clk);
        bus_addr = a;
        repeat (STB + 6) @(posedge clk);
        @(negedge clk);
        chk(tag, int'(bus_drive), int'(exp_drv));
        if (exp_drv) chk(tag, int'(bus_data), exp_dat);
    endtask

    task automatic load_ptr(input logic [11:0] v);
        @(negedge clk);
        jload = 1'b1;
        jval  = v;
        @(negedge clk);
        jload = 1'b0;
        chk("R9", int'(jptr), int'(v));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            rom[i] = 8'((i * 7 + 3) & 255);
            ram[i] = 8'((i * 13 + 5) & 255);
        end
        rom[12'h0B6] = 8'hEA; rom[12'h0B7] = 8'h4C; rom[12'h0B8] = 8'h00; rom[12'h0B9] = 8'h00;
        rom[12'h200] = 8'h4C; rom[12'h201] = 8'h00; rom[12'h202] = 8'hF0;
        rom[12'h300] = 8'h4C; rom[12'h301] = 8'h00; rom[12'h302] = 8'h00;
        ram[4] = 8'hBA; ram[5] = 8'hF0;
        ram[12'hFFE] = 8'h11; ram[12'hFFF] = 8'h22; ram[0] = 8'h77;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", int'(bus_drive), 0);
        chk("R10", int'(jptr), 0);
        rst = 1'b0;

        phase = "R1";
        visit(13'h0005, "R1", 0, 0);
        phase = "R2";
        visit(13'h1005, "R2", 1, rom[12'h005]);
        visit(13'h1FFF, "R2", 1, rom[12'hFFF]);
        // R2 latency: old byte after STB+3 edges, new after STB+4
        @(negedge clk);
        bus_addr = 13'h1ABC;
        repeat (STB + 3) @(posedge clk);
        @(negedge clk);
        chk("R2", int'(bus_data), rom[12'hFFF]);
        @(negedge clk);
        chk("R2", int'(bus_data), rom[12'hABC]);
        repeat (STB + 4) @(posedge clk);

        phase = "R4";
        visit(13'h1005, "R4", 1, rom[12'h005]);
        @(negedge clk);
        bus_addr = 13'h1006;
        repeat (STB) @(posedge clk);
        @(negedge clk);
        bus_addr = 13'h1005;
        repeat (STB + 6) @(posedge clk);
        @(negedge clk);
        chk("R4", int'(bus_data), rom[12'h005]);

        phase = "R9";
        load_ptr(12'h004);

        phase = "R5";
        visit(13'h10B6, "R3", 1, 8'hEA);
        // dummy read and opcode fetch merge into one held address
        @(negedge clk);
        bus_addr = 13'h10B7;
        repeat (4 * STB + 20) @(posedge clk);
        @(negedge clk);
        chk("R3", int'(bus_data), 8'h4C);
        chk("R3", int'(jptr), 12'h004);
        visit(13'h10B8, "R5", 1, 8'hBA);
        visit(13'h10B9, "R5", 1, 8'hF0);
        chk("R6", int'(jptr), 12'h006);
        phase = "R3";
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R3", int'(jptr), 12'h006);
        visit(13'h10B8, "R3", 1, 8'h00);

        phase = "R7";
        visit(13'h1200, "R7", 1, 8'h4C);
        visit(13'h1201, "R7", 1, 8'h00);
        visit(13'h1202, "R7", 1, 8'hF0);
        chk("R7", int'(jptr), 12'h006);

        phase = "R8";
        visit(13'h1300, "R8", 1, 8'h4C);
        visit(13'h1050, "R8", 1, rom[12'h050]);
        visit(13'h1301, "R8", 1, 8'h00);
        visit(13'h1300, "R8", 1, 8'h4C);
        visit(13'h1301, "R8", 1, ram[6]);
        visit(13'h1000, "R8", 1, rom[12'h000]);
        visit(13'h1302, "R8", 1, 8'h00);
        chk("R8", int'(jptr), 12'h006);

        phase = "R1";
        visit(13'h1300, "R1", 1, 8'h4C);
        visit(13'h0301, "R1", 0, 0);
        visit(13'h1301, "R1", 1, 8'h00);

        phase = "R6";
        load_ptr(12'hFFE);
        visit(13'h10B6, "R6", 1, 8'hEA);
        visit(13'h10B7, "R6", 1, 8'h4C);
        visit(13'h10B8, "R6", 1, 8'h11);
        visit(13'h10B9, "R6", 1, 8'h22);
        chk("R6", int'(jptr), 12'h000);

        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule